// File: doc/BRIEF.md
# Serial Audio Receiver with Selectable Framing

This block takes a stereo serial audio stream (bit clock, word select and data) from an external source and turns each left/right pair into two parallel samples, left-aligned in a fixed-width output word, plus a single-cycle strobe. It never drives the bit clock or word select. It follows them as a slave: all three pins are brought into the system clock domain, and every rising bit-clock edge is handled as one received bit.

A three-bit format input selects the framing at run time:

- I2S, where the first data bit trails the word-select change by one bit clock.
- Left-justified, where the first data bit coincides with the change.
- One of four right-justified variants, where the sample is the final 16, 18, 20 or 24 bits before the word-select change.

The two unused codes behave exactly like the I2S code. Word select low marks the left channel. A pair is published only when a complete left slot has been followed by a complete right slot.

Top module: `aud_rx_top`

## Requirements
- R1: While reset is asserted and afterwards until the first pair, `left_smp` and `right_smp` are zero and `smp_vld` is low.
- R2: With `fmt_sel` = 000 (I2S), the sample's MSB is the bit taken on the second rising bit-clock edge of a slot. Bits are taken MSB first, and the bit taken on the edge where word select changes is the last bit of the slot that ends there.
- R3: With `fmt_sel` = 101 (left-justified), the MSB is the bit taken on the first rising bit-clock edge at which word select shows its new level.
- R4: `fmt_sel` values 110 and 111 give exactly the result of 000.
- R5: With `fmt_sel` = 001, 010, 011 or 100 (right-justified), the sample is the last 16, 18, 20 or 24 bits taken before the word-select change, whatever the slot length. It is placed in the top bits of the output word, and the remaining low bits are zero even when the slot's earlier bits are ones.
- R6: In the I2S and left-justified framings, a slot carrying fewer than SMP_W bits gives a sample zero-filled below its last bit, and bits past the first SMP_W of a slot are discarded.
- R7: `smp_vld` is high for exactly one clock, after a right slot (word select high) has closed. It presents that right sample together with the left sample of the slot just before it.
- R8: `left_smp` and `right_smp` change only in a cycle where `smp_vld` is high. A lone left slot leaves them untouched.
- R9: The slot in progress when reset is released is discarded. A right slot whose left slot was discarded produces no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_in | input | 1 | External serial bit clock |
| ws_in | input | 1 | External word select (low = left) |
| sd_in | input | 1 | Serial data, sampled on rising bit clock |
| fmt_sel | input | 3 | Framing selector |
| left_smp | output | SMP_W | Left sample, MSB-aligned |
| right_smp | output | SMP_W | Right sample, MSB-aligned |
| smp_vld | output | 1 | One-cycle pair strobe |

## Verification
The bench fills the padding bits of every right-justified slot with ones. A receiver that masks with the wrong width then shows those ones in its output instead of zero padding.

It runs I2S slots both shorter and longer than the sample width. This exposes an off-by-one in where the word-select edge splits the slot: such a design would rotate every sample by one bit or drop its LSB.

A lone left slot is sent, and a stream is started mid-slot after reset. A design that publishes per channel would change the outputs early, and one that forgets the partial first slot would emit a bogus first pair.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FK_I2S = 2'd0,
    FK_MSB = 2'd1,
    FK_LSB = 2'd2
  } fmt_kind_e;

  localparam int WIDTH_FW = 6;

  typedef struct packed {
    fmt_kind_e             kind;
    logic [WIDTH_FW-1:0]   bits;
  } fmt_cfg_t;

endpackage

// File: rtl/aud_pin_sync.sv
module aud_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_pin,
  input  logic ws_pin,
  input  logic sd_pin,
  output logic bit_stb,
  output logic ws_bit,
  output logic sd_bit
);

  logic [STAGES:0]   bck_q, bck_d;
  logic [STAGES-1:0] ws_q, ws_d;
  logic [STAGES-1:0] sd_q, sd_d;

  always_comb begin
    bck_d = {bck_q[STAGES-1:0], bck_pin};
    ws_d  = {ws_q[STAGES-2:0], ws_pin};
    sd_d  = {sd_q[STAGES-2:0], sd_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q <= '0;
      ws_q  <= '0;
      sd_q  <= '0;
    end else begin
      bck_q <= bck_d;
      ws_q  <= ws_d;
      sd_q  <= sd_d;
    end
  end

  // word select and data are delayed as deep as the bit clock, so the
  // values seen at the edge strobe are those present at the pin edge
  assign bit_stb = bck_q[STAGES-1] & ~bck_q[STAGES];
  assign ws_bit  = ws_q[STAGES-1];
  assign sd_bit  = sd_q[STAGES-1];

endmodule

// File: rtl/aud_fmt_dec.sv
module aud_fmt_dec
  import aud_rx_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] fmt_code,
  output fmt_cfg_t   cfg
);

  localparam logic [WIDTH_FW-1:0] B_FULL = WIDTH_FW'(SMP_W);
  localparam logic [WIDTH_FW-1:0] B16 = WIDTH_FW'((SMP_W < 16) ? SMP_W : 16);
  localparam logic [WIDTH_FW-1:0] B18 = WIDTH_FW'((SMP_W < 18) ? SMP_W : 18);
  localparam logic [WIDTH_FW-1:0] B20 = WIDTH_FW'((SMP_W < 20) ? SMP_W : 20);
  localparam logic [WIDTH_FW-1:0] B24 = WIDTH_FW'((SMP_W < 24) ? SMP_W : 24);

  fmt_cfg_t cfg_d;

  always_comb begin
    case (fmt_code)
      3'b001:  cfg_d = '{kind: FK_LSB, bits: B16};
      3'b010:  cfg_d = '{kind: FK_LSB, bits: B18};
      3'b011:  cfg_d = '{kind: FK_LSB, bits: B20};
      3'b100:  cfg_d = '{kind: FK_LSB, bits: B24};
      3'b101:  cfg_d = '{kind: FK_MSB, bits: B_FULL};
      default: cfg_d = '{kind: FK_I2S, bits: B_FULL}; // 000 and unused codes
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '{kind: FK_I2S, bits: B_FULL};
    else        cfg <= cfg_d;
  end

endmodule

// File: rtl/aud_slot_capture.sv
module aud_slot_capture
  import aud_rx_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             ws_bit,
  input  logic             sd_bit,
  input  fmt_cfg_t         cfg,
  output logic             word_stb,
  output logic             word_ch,
  output logic [SMP_W-1:0] word_data
);

  localparam int CW = $clog2(SMP_W + 1);
  localparam logic [CW-1:0] FULL = CW'(SMP_W);

  logic [SMP_W-1:0] sh_q, sh_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ws_prev_q, ws_prev_d;
  logic             have_prev_q, have_prev_d;
  logic             in_slot_q, in_slot_d;

  logic             ws_edge;
  logic             cnt_full;
  logic [SMP_W-1:0] shifted;
  logic [SMP_W-1:0] lsb_mask;
  logic [SMP_W-1:0] coll;
  logic [CW-1:0]    coll_n;

  always_comb begin
    ws_edge  = bit_stb & have_prev_q & (ws_bit != ws_prev_q);
    cnt_full = (cnt_q == FULL);
    shifted  = {sh_q[SMP_W-2:0], sd_bit};
    lsb_mask = ~({SMP_W{1'b1}} << cfg.bits);
    case (cfg.kind)
      FK_I2S: begin
        if (!cnt_full) begin
          coll   = shifted;      // bit at the edge ends the old slot
          coll_n = cnt_q + CW'(1);
        end else begin
          coll   = sh_q;
          coll_n = cnt_q;
        end
      end
      FK_LSB: begin
        coll   = sh_q & lsb_mask;
        coll_n = CW'(cfg.bits);
      end
      default: begin
        coll   = sh_q;
        coll_n = cnt_q;
      end
    endcase
    word_data = coll << (FULL - coll_n);
    word_stb  = ws_edge & in_slot_q;
    word_ch   = ws_prev_q;
  end

  always_comb begin
    sh_d        = sh_q;
    cnt_d       = cnt_q;
    ws_prev_d   = ws_prev_q;
    have_prev_d = have_prev_q;
    in_slot_d   = in_slot_q;
    if (bit_stb) begin
      ws_prev_d   = ws_bit;
      have_prev_d = 1'b1;
      if (ws_edge) begin
        in_slot_d = 1'b1;
        case (cfg.kind)
          FK_I2S: begin
            sh_d  = '0;
            cnt_d = '0;
          end
          FK_MSB: begin
            sh_d  = {{(SMP_W-1){1'b0}}, sd_bit};
            cnt_d = CW'(1);
          end
          default: sh_d = shifted;
        endcase
      end else if (cfg.kind == FK_LSB) begin
        sh_d = shifted;
      end else if (!cnt_full) begin
        sh_d  = shifted;
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q        <= '0;
      cnt_q       <= '0;
      ws_prev_q   <= 1'b0;
      have_prev_q <= 1'b0;
      in_slot_q   <= 1'b0;
    end else begin
      sh_q        <= sh_d;
      cnt_q       <= cnt_d;
      ws_prev_q   <= ws_prev_d;
      have_prev_q <= have_prev_d;
      in_slot_q   <= in_slot_d;
    end
  end

endmodule

// File: rtl/aud_pair_out.sv
module aud_pair_out #(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_stb,
  input  logic             word_ch,
  input  logic [SMP_W-1:0] word_data,
  output logic [SMP_W-1:0] left_q,
  output logic [SMP_W-1:0] right_q,
  output logic             vld_q
);

  logic [SMP_W-1:0] hold_q, hold_d;
  logic             left_ok_q, left_ok_d;
  logic [SMP_W-1:0] left_d, right_d;
  logic             vld_d;

  always_comb begin
    hold_d    = hold_q;
    left_ok_d = left_ok_q;
    left_d    = left_q;
    right_d   = right_q;
    vld_d     = 1'b0;
    if (word_stb) begin
      if (!word_ch) begin
        hold_d    = word_data;
        left_ok_d = 1'b1;
      end else begin
        left_ok_d = 1'b0;
        if (left_ok_q) begin
          left_d  = hold_q;
          right_d = word_data;
          vld_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      left_ok_q <= 1'b0;
      left_q    <= '0;
      right_q   <= '0;
      vld_q     <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      left_ok_q <= left_ok_d;
      left_q    <= left_d;
      right_q   <= right_d;
      vld_q     <= vld_d;
    end
  end

endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
  import aud_rx_pkg::*;
#(
  parameter int SMP_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bck_in,
  input  logic             ws_in,
  input  logic             sd_in,
  input  logic [2:0]       fmt_sel,
  output logic [SMP_W-1:0] left_smp,
  output logic [SMP_W-1:0] right_smp,
  output logic             smp_vld
);

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             bit_stb, ws_bit, sd_bit;
  fmt_cfg_t         cfg;
  logic             cap_stb, cap_ch;
  logic [SMP_W-1:0] cap_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  aud_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s),
    .bck_pin(bck_in), .ws_pin(ws_in), .sd_pin(sd_in),
    .bit_stb(bit_stb), .ws_bit(ws_bit), .sd_bit(sd_bit)
  );

  aud_fmt_dec #(.SMP_W(SMP_W)) u_fmt (
    .clk(clk), .rst_n(rst_n_s), .fmt_code(fmt_sel), .cfg(cfg)
  );

  aud_slot_capture #(.SMP_W(SMP_W)) u_cap (
    .clk(clk), .rst_n(rst_n_s),
    .bit_stb(bit_stb), .ws_bit(ws_bit), .sd_bit(sd_bit), .cfg(cfg),
    .word_stb(cap_stb), .word_ch(cap_ch), .word_data(cap_word)
  );

  aud_pair_out #(.SMP_W(SMP_W)) u_out (
    .clk(clk), .rst_n(rst_n_s),
    .word_stb(cap_stb), .word_ch(cap_ch), .word_data(cap_word),
    .left_q(left_smp), .right_q(right_smp), .vld_q(smp_vld)
  );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk
  import aud_rx_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       fmt_sel,
  input fmt_cfg_t         cfg,
  input logic             bit_stb,
  input logic             cap_stb,
  input logic             cap_ch,
  input logic [SMP_W-1:0] cap_word,
  input logic             smp_vld,
  input logic [SMP_W-1:0] left_smp,
  input logic [SMP_W-1:0] right_smp
);

  p_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel[2:1] == 2'b11) |=> (cfg.kind == FK_I2S && cfg.bits == WIDTH_FW'(SMP_W)));

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && cfg.kind == FK_LSB) |-> ((cap_word & ({SMP_W{1'b1}} >> cfg.bits)) == '0));

  p_close_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> bit_stb);

  p_vld_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> !smp_vld);

  p_vld_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> $past(cap_stb && cap_ch));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |-> ($stable(left_smp) && $stable(right_smp)));

endmodule

bind aud_rx_top aud_rx_chk #(.SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .fmt_sel(fmt_sel), .cfg(cfg),
  .bit_stb(bit_stb), .cap_stb(cap_stb), .cap_ch(cap_ch), .cap_word(cap_word),
  .smp_vld(smp_vld), .left_smp(left_smp), .right_smp(right_smp)
);

// File: tb/tb_aud_rx_top.sv
`timescale 1ns/1ps
module tb_aud_rx_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
  logic [2:0]  fmt_sel = 3'b000;
  logic [23:0] left_smp, right_smp;
  logic        smp_vld;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic i2s_dly = 1'b0, d_hold = 1'b0;

  logic [23:0] ml [0:63];
  logic [23:0] mr [0:63];
  int          mn = 0;
  logic        pv = 1'b0;
  logic [23:0] pl = '0, pr = '0;

  always #5 clk = ~clk;

  aud_rx_top dut (
    .clk(clk), .rst_n(rst_n), .bck_in(bck_in), .ws_in(ws_in), .sd_in(sd_in),
    .fmt_sel(fmt_sel), .left_smp(left_smp), .right_smp(right_smp), .smp_vld(smp_vld)
  );

  // pair monitor: records pairs, checks pulse width (R7) and hold (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_vld) begin
        ml[mn % 64] = left_smp;
        mr[mn % 64] = right_smp;
        mn++;
        n_chk++;
        if (pv) begin
          n_err++;
          $display("FAIL R7 valid high two cycles: act=1 exp=0");
        end
      end else if (left_smp != pl || right_smp != pr) begin
        n_chk++; n_err++;
        $display("FAIL R8 outputs moved without valid: act=%h/%h exp=%h/%h",
                 left_smp, right_smp, pl, pr);
      end
    end
    pv = smp_vld; pl = left_smp; pr = right_smp;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] e_msb(input logic [63:0] p, input int len);
    logic [23:0] e;
    for (int i = 0; i < 24; i++) begin
      int idx = len - 1 - i;
      e[23-i] = (idx >= 0) ? p[idx] : 1'b0;
    end
    return e;
  endfunction

  function automatic logic [23:0] e_lsb(input logic [63:0] p, input int n);
    logic [23:0] e;
    for (int i = 0; i < 24; i++) e[23-i] = (i < n) ? p[n-1-i] : 1'b0;
    return e;
  endfunction

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    bck_in = 1'b0; ws_in = w;
    sd_in  = i2s_dly ? d_hold : d;
    d_hold = d;
    repeat (4) @(negedge clk);
    bck_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_slot(input logic w, input logic [63:0] p, input int len);
    for (int k = len - 1; k >= 0; k--) send_bit(w, p[k]);
  endtask

  task automatic do_reset(input logic [2:0] f, input logic dly);
    fmt_sel = f; i2s_dly = dly; d_hold = 1'b0;
    bck_in = 1'b0; ws_in = 1'b0; sd_in = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(3'b000, 1'b0);
    check(left_smp == 24'h0,  "R1 left after reset",  32'(left_smp), 32'h0);
    check(right_smp == 24'h0, "R1 right after reset", 32'(right_smp), 32'h0);
    check(smp_vld == 1'b0,    "R1 valid after reset", 32'(smp_vld), 32'h0);
  endtask

  // two pairs; lsbn==0 selects the I2S/left-justified expectation
  task automatic pair_test(input string tag, input logic [2:0] f, input logic dly,
                           input int len, input int lsbn,
                           input logic [63:0] l1, input logic [63:0] r1,
                           input logic [63:0] l2, input logic [63:0] r2);
    int base;
    logic [23:0] el1, er1, el2, er2;
    do_reset(f, dly);
    base = mn;
    el1 = (lsbn == 0) ? e_msb(l1, len) : e_lsb(l1, lsbn);
    er1 = (lsbn == 0) ? e_msb(r1, len) : e_lsb(r1, lsbn);
    el2 = (lsbn == 0) ? e_msb(l2, len) : e_lsb(l2, lsbn);
    er2 = (lsbn == 0) ? e_msb(r2, len) : e_lsb(r2, lsbn);
    send_slot(1'b1, 64'h5, 3);
    send_slot(1'b0, l1, len); send_slot(1'b1, r1, len);
    send_slot(1'b0, l2, len); send_slot(1'b1, r2, len);
    send_slot(1'b0, 64'h0, 3);
    repeat (10) @(negedge clk);
    check(mn - base == 2, {tag, " pair count"}, 32'(mn - base), 32'd2);
    check(ml[base % 64] == el1, {tag, " left 1"},  32'(ml[base % 64]), 32'(el1));
    check(mr[base % 64] == er1, {tag, " right 1"}, 32'(mr[base % 64]), 32'(er1));
    check(ml[(base+1) % 64] == el2, {tag, " left 2"},  32'(ml[(base+1) % 64]), 32'(el2));
    check(mr[(base+1) % 64] == er2, {tag, " right 2"}, 32'(mr[(base+1) % 64]), 32'(er2));
  endtask

  // R8: a lone left slot must not disturb the published pair
  task automatic t_hold;
    int base;
    do_reset(3'b101, 1'b0);
    base = mn;
    send_slot(1'b1, 64'h1, 2);
    send_slot(1'b0, 64'hA1B2C3D4, 32);
    send_slot(1'b1, 64'h11223344, 32);
    send_slot(1'b0, 64'hFFFFFFFF, 32);
    repeat (6) @(negedge clk);
    check(mn - base == 1, "R8 one pair before lone left", 32'(mn - base), 32'd1);
    check(left_smp == 24'hA1B2C3, "R8 left held", 32'(left_smp), 32'hA1B2C3);
    check(right_smp == 24'h112233, "R8 right held", 32'(right_smp), 32'h112233);
    send_slot(1'b1, 64'h0F0F0F0F, 32);
    send_slot(1'b0, 64'h0, 2);
    repeat (10) @(negedge clk);
    check(mn - base == 2, "R8 second pair", 32'(mn - base), 32'd2);
    check(left_smp == 24'hFFFFFF, "R8 second left", 32'(left_smp), 32'hFFFFFF);
  endtask

  // R9: stream begins mid left slot after reset
  task automatic t_midstart;
    int base;
    do_reset(3'b101, 1'b0);
    base = mn;
    send_slot(1'b0, 64'h3FF, 10);
    send_slot(1'b1, 64'hDEADBEEF, 32);
    send_slot(1'b0, 64'h13579BDF, 32);
    send_slot(1'b1, 64'h2468ACE0, 32);
    send_slot(1'b0, 64'h0, 2);
    repeat (10) @(negedge clk);
    check(mn - base == 1, "R9 partial slot discarded", 32'(mn - base), 32'd1);
    check(left_smp == 24'h13579B, "R9 left", 32'(left_smp), 32'h13579B);
    check(right_smp == 24'h2468AC, "R9 right", 32'(right_smp), 32'h2468AC);
  endtask

  initial begin
    t_reset;
    pair_test("R2 i2s 32", 3'b000, 1'b1, 32, 0,
              64'h9ABCDEF1, 64'h80000001, 64'h7F00FF80, 64'hC3C3C3C3);
    pair_test("R6 i2s 20", 3'b000, 1'b1, 20, 0,
              64'hABCDE, 64'h80001, 64'h5A5A5, 64'hFFFFF);
    pair_test("R3 R6 msb 32", 3'b101, 1'b0, 32, 0,
              64'h123456FF, 64'hFEDCBAFF, 64'h800000FF, 64'h000001FF);
    pair_test("R6 msb 16", 3'b101, 1'b0, 16, 0,
              64'hBEEF, 64'h8001, 64'h1234, 64'hFFFF);
    pair_test("R4 code 110", 3'b110, 1'b1, 32, 0,
              64'h9ABCDEF1, 64'h80000001, 64'h7F00FF80, 64'hC3C3C3C3);
    pair_test("R4 code 111", 3'b111, 1'b1, 24, 0,
              64'hA5A5A5, 64'h800001, 64'h0FF0F0, 64'h123456);
    pair_test("R5 lsb16", 3'b001, 1'b0, 32, 16,
              64'hFFFF8001, 64'hFFFF7FFE, 64'hFFFF1234, 64'hFFFFFEDC);
    pair_test("R5 lsb18", 3'b010, 1'b0, 32, 18,
              64'hFFFE0001, 64'hFFFF3FFF, 64'hFFFC8421, 64'hFFFD2345);
    pair_test("R5 lsb20", 3'b011, 1'b0, 32, 20,
              64'hFFF80001, 64'hFFF7FFFF, 64'hFFFABCDE, 64'hFFF12345);
    pair_test("R5 lsb24", 3'b100, 1'b0, 32, 24,
              64'hFF800001, 64'hFF7FFFFF, 64'hFF123456, 64'hFFABCDEF);
    pair_test("R5 lsb24 tight", 3'b100, 1'b0, 24, 24,
              64'h800001, 64'h7FFFFF, 64'h123456, 64'hABCDEF);
    t_hold;
    t_midstart;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule